// File: doc/BRIEF.md
# Second-Layer Trigger Combiner

This block sits in the middle layer of a tree of trigger boards. Each cycle it takes one summary word from each of several first-layer boards. Each word carries a 10-bit energy sum and three 2-bit level grades: a high-tower grade, a patch grade and a ratio grade. The block ORs each grade field across all inputs to make a 6-bit flag group. It adds the energy fields into a jet energy, grades that energy against three programmable thresholds and scales it down to an 8-bit energy figure. It packs all of this into one 16-bit word for the next layer.

The three thresholds are loaded through a small write-only configuration port. Every cycle produces a result, one clock after the inputs are sampled. With the default parameters there are five input words, the jet energy is 13 bits wide and the comparison is "greater than or equal".

Top module: `trig_l2_combiner`

## Requirements
- R1: While reset is asserted, `out_word` is zero and all three thresholds are loaded with all ones (8191). With these thresholds every reachable jet energy (at most 5115) grades as level 0.
- R2: Each input word i sits at `in_words[16*i+15:16*i]`. In that word, bits [9:0] are energy, [11:10] the high-tower grade, [13:12] the patch grade and [15:14] the ratio grade. `out_word[1:0]`, `[3:2]` and `[5:4]` are the bitwise OR of the high-tower, patch and ratio grades over all five words.
- R3: The jet energy is the sum of the five energy fields, held at 13 bits without loss. `out_word[15:8]` carries that sum shifted right by 5, clamped to 255.
- R4: `out_word[7:6]` is the count of thresholds that the jet energy is greater than or equal to (0 to 3). This count applies for any threshold values, in order or not.
- R5: A cycle with `cfg_we` high and `cfg_sel` equal to 0, 1 or 2 loads `cfg_data` into threshold 0, 1 or 2 at that clock edge. Data sampled at that same edge is still graded against the old value. Data sampled at the next edge uses the new value.
- R6: A write with `cfg_sel` equal to 3 changes no threshold.
- R7: Inputs sampled at a clock edge appear on `out_word` right after that edge. `out_word` holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_words | input | 80 | Five packed first-layer summary words |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Threshold index (3 selects none) |
| cfg_data | input | 13 | Threshold value to load |
| out_word | output | 16 | Packed result: energy, jet level, OR flags |

## Verification
A threshold write and the grading of new data can fall on the same clock edge. The bench provokes this by presenting a fresh jet energy in the same cycle as a write that lowers threshold 0 below it. The result of that edge must still carry the old grade. The same data, held one more cycle, must then carry the raised grade. Threshold sweeps at and around each boundary, including thresholds out of order, check the count-based grading. Single-bit flag sweeps over every input and field check the OR merging.

// File: rtl/trig_l2_pkg.sv
package trig_l2_pkg;
   // number of grade fields carried in each summary word
   localparam int unsigned NUM_FLD = 3;
   // number of programmable jet thresholds
   localparam int unsigned NUM_THR = 3;
   localparam int unsigned SEL_W   = $clog2(NUM_THR + 1);

   typedef enum logic [SEL_W-1:0] {
      SEL_T0   = 2'd0,
      SEL_T1   = 2'd1,
      SEL_T2   = 2'd2,
      SEL_NONE = 2'd3
   } thr_sel_e;
endpackage

// File: rtl/trig_l2_thresh_regs.sv
module trig_l2_thresh_regs #(
   parameter int unsigned SUM_W   = 13,
   parameter int unsigned NUM_THR = 3,
   parameter int unsigned SEL_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [SEL_W-1:0]           sel,
   input  logic [SUM_W-1:0]           data,
   output logic [NUM_THR*SUM_W-1:0]   thr_o
);
   for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
      logic [SUM_W-1:0] thr_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            thr_q <= '1;
         else if (we && (sel == SEL_W'(k)))
            thr_q <= data;
      end
      assign thr_o[k*SUM_W +: SUM_W] = thr_q;
   end
endmodule

// File: rtl/trig_l2_flag_or.sv
module trig_l2_flag_or #(
   parameter int unsigned NUM_IN  = 5,
   parameter int unsigned NUM_FLD = 3,
   parameter int unsigned LVL_W   = 2,
   localparam int unsigned GRP_W  = NUM_FLD * LVL_W
) (
   input  logic [NUM_IN*GRP_W-1:0] grades_i,
   output logic [GRP_W-1:0]        flags_o
);
   always_comb begin
      flags_o = '0;
      for (int i = 0; i < NUM_IN; i++)
         flags_o = flags_o | grades_i[i*GRP_W +: GRP_W];
   end
endmodule

// File: rtl/trig_l2_jet_grade.sv
module trig_l2_jet_grade #(
   parameter int unsigned NUM_IN     = 5,
   parameter int unsigned E_W        = 10,
   parameter int unsigned SUM_W      = 13,
   parameter int unsigned NUM_THR    = 3,
   parameter int unsigned LVL_OUT_W  = 2,
   parameter int unsigned SHIFT      = 5,
   parameter int unsigned OUT_E_W    = 8,
   parameter bit          GE_COMPARE = 1'b1
) (
   input  logic [NUM_IN*E_W-1:0]     energy_i,
   input  logic [NUM_THR*SUM_W-1:0]  thr_i,
   output logic [LVL_OUT_W-1:0]      level_o,
   output logic [OUT_E_W-1:0]        energy_o
);
   logic [SUM_W-1:0]   jet_sum;
   logic [NUM_THR-1:0] pass;

   always_comb begin
      jet_sum = '0;
      for (int i = 0; i < NUM_IN; i++)
         jet_sum = jet_sum + SUM_W'(energy_i[i*E_W +: E_W]);
   end

   for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
      if (GE_COMPARE) begin : g_ge
         assign pass[k] = (jet_sum >= thr_i[k*SUM_W +: SUM_W]);
      end else begin : g_gt
         assign pass[k] = (jet_sum > thr_i[k*SUM_W +: SUM_W]);
      end
   end

   always_comb begin
      level_o = '0;
      for (int k = 0; k < NUM_THR; k++)
         if (pass[k]) level_o = level_o + LVL_OUT_W'(1);
   end

   if (SUM_W - SHIFT <= OUT_E_W) begin : g_fit
      assign energy_o = OUT_E_W'(jet_sum >> SHIFT);
   end else begin : g_clamp
      localparam logic [SUM_W-1:0] CAP = SUM_W'((1 << OUT_E_W) - 1);
      logic [SUM_W-1:0] scaled;
      assign scaled   = jet_sum >> SHIFT;
      assign energy_o = (scaled > CAP) ? '1 : scaled[OUT_E_W-1:0];
   end
endmodule

// File: rtl/trig_l2_combiner.sv
module trig_l2_combiner #(
   parameter int unsigned NUM_IN     = 5,
   parameter int unsigned E_W        = 10,
   parameter int unsigned LVL_W      = 2,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned SHIFT      = 5,
   parameter int unsigned OUT_E_W    = 8,
   parameter bit          GE_COMPARE = 1'b1,
   localparam int unsigned NUM_FLD   = trig_l2_pkg::NUM_FLD,
   localparam int unsigned NUM_THR   = trig_l2_pkg::NUM_THR,
   localparam int unsigned SEL_W     = trig_l2_pkg::SEL_W,
   localparam int unsigned SUM_W     = E_W + $clog2(NUM_IN),
   localparam int unsigned LVL_OUT_W = $clog2(NUM_THR + 1),
   localparam int unsigned GRP_W     = NUM_FLD * LVL_W,
   localparam int unsigned OUT_W     = GRP_W + LVL_OUT_W + OUT_E_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IN*WORD_W-1:0] in_words,
   input  logic                     cfg_we,
   input  logic [SEL_W-1:0]         cfg_sel,
   input  logic [SUM_W-1:0]         cfg_data,
   output logic [OUT_W-1:0]         out_word
);
   if (WORD_W != E_W + GRP_W) begin : g_bad_word
      $error("summary word width does not match energy plus grade fields");
   end
   if (NUM_IN < 1) begin : g_bad_num
      $error("at least one input word is required");
   end
   if (SHIFT >= SUM_W) begin : g_bad_shift
      $error("energy shift removes the whole jet sum");
   end

   logic [NUM_IN*E_W-1:0]    energy_w;
   logic [NUM_IN*GRP_W-1:0]  grade_w;
   logic [NUM_THR*SUM_W-1:0] thr_w;
   logic [GRP_W-1:0]         flags_w;
   logic [LVL_OUT_W-1:0]     level_w;
   logic [OUT_E_W-1:0]       escaled_w;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_split
      assign energy_w[i*E_W +: E_W]  = in_words[i*WORD_W +: E_W];
      assign grade_w[i*GRP_W +: GRP_W] = in_words[i*WORD_W + E_W +: GRP_W];
   end

   trig_l2_thresh_regs #(.SUM_W(SUM_W), .NUM_THR(NUM_THR), .SEL_W(SEL_W)) u_thr (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
      .thr_o(thr_w)
   );

   trig_l2_flag_or #(.NUM_IN(NUM_IN), .NUM_FLD(NUM_FLD), .LVL_W(LVL_W)) u_or (
      .grades_i(grade_w), .flags_o(flags_w)
   );

   trig_l2_jet_grade #(
      .NUM_IN(NUM_IN), .E_W(E_W), .SUM_W(SUM_W), .NUM_THR(NUM_THR),
      .LVL_OUT_W(LVL_OUT_W), .SHIFT(SHIFT), .OUT_E_W(OUT_E_W),
      .GE_COMPARE(GE_COMPARE)
   ) u_jet (
      .energy_i(energy_w), .thr_i(thr_w), .level_o(level_w), .energy_o(escaled_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         out_word <= '0;
      else
         out_word <= {escaled_w, level_w, flags_w};
   end
endmodule

// File: rtl/trig_l2_combiner_chk.sv
module trig_l2_combiner_chk #(
   parameter int unsigned NUM_IN     = 5,
   parameter int unsigned E_W        = 10,
   parameter int unsigned LVL_W      = 2,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned SHIFT      = 5,
   parameter int unsigned OUT_E_W    = 8,
   parameter bit          GE_COMPARE = 1'b1,
   parameter int unsigned NUM_FLD    = 3,
   parameter int unsigned NUM_THR    = 3,
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned SUM_W      = 13,
   parameter int unsigned LVL_OUT_W  = 2,
   parameter int unsigned OUT_W      = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_IN*WORD_W-1:0] in_words,
   input logic                     cfg_we,
   input logic [SEL_W-1:0]         cfg_sel,
   input logic [SUM_W-1:0]         cfg_data,
   input logic [NUM_THR*SUM_W-1:0] thr,
   input logic [OUT_W-1:0]         out_word
);
   localparam int unsigned GRP_W = NUM_FLD * LVL_W;

   logic [GRP_W-1:0]     m_flags;
   logic [SUM_W+1:0]     m_sum;
   logic [OUT_E_W-1:0]   m_energy;
   logic [LVL_OUT_W-1:0] m_level;

   always_comb begin
      m_flags = '0;
      m_sum   = '0;
      for (int i = 0; i < NUM_IN; i++) begin
         m_flags = m_flags | in_words[i*WORD_W + E_W +: GRP_W];
         m_sum   = m_sum + (SUM_W+2)'(in_words[i*WORD_W +: E_W]);
      end
      if ((m_sum >> SHIFT) > (SUM_W+2)'((1 << OUT_E_W) - 1))
         m_energy = '1;
      else
         m_energy = OUT_E_W'(m_sum >> SHIFT);
      m_level = '0;
      for (int k = 0; k < NUM_THR; k++)
         if (GE_COMPARE ? (m_sum >= (SUM_W+2)'(thr[k*SUM_W +: SUM_W]))
                        : (m_sum >  (SUM_W+2)'(thr[k*SUM_W +: SUM_W])))
            m_level = m_level + LVL_OUT_W'(1);
   end

   // R2 and R7: merged grades appear one edge after sampling
   a_r2_flag_or: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_word[GRP_W-1:0] == $past(m_flags));

   // R3: scaled and clamped energy
   a_r3_energy_scale: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_word[OUT_W-1 -: OUT_E_W] == $past(m_energy));

   // R4: level counts passed thresholds held at the sampling edge
   a_r4_level_count: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_word[GRP_W +: LVL_OUT_W] == $past(m_level));

   // R5: a selected threshold takes the written value
   for (genvar k = 0; k < NUM_THR; k++) begin : g_wr
      a_r5_thr_load: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_sel == SEL_W'(k)) |=> thr[k*SUM_W +: SUM_W] == $past(cfg_data));
   end

   // R6: the spare select value leaves all thresholds alone
   a_r6_sel_spare: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(NUM_THR)) |=> $stable(thr));
endmodule

bind trig_l2_combiner trig_l2_combiner_chk #(
   .NUM_IN(NUM_IN), .E_W(E_W), .LVL_W(LVL_W), .WORD_W(WORD_W), .SHIFT(SHIFT),
   .OUT_E_W(OUT_E_W), .GE_COMPARE(GE_COMPARE), .NUM_FLD(NUM_FLD),
   .NUM_THR(NUM_THR), .SEL_W(SEL_W), .SUM_W(SUM_W), .LVL_OUT_W(LVL_OUT_W),
   .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_words(in_words), .cfg_we(cfg_we),
   .cfg_sel(cfg_sel), .cfg_data(cfg_data), .thr(thr_w), .out_word(out_word)
);

// File: tb/trig_l2_combiner_bench.sv
`timescale 1ns/1ps
module trig_l2_combiner_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [79:0] in_words = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [12:0] cfg_data = '0;
   logic [15:0] out_word;

   int nchk = 0;
   int nerr = 0;
   int e[5];
   int f[5][3];
   int thr[3];

   always #2 clk = ~clk;

   trig_l2_combiner u_trig_l2_combiner (
      .clk(clk), .rst_n(rst_n), .in_words(in_words), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .out_word(out_word)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive_in();
      for (int i = 0; i < 5; i++)
         in_words[i*16 +: 16] = {f[i][2][1:0], f[i][1][1:0], f[i][0][1:0], e[i][9:0]};
   endtask

   function automatic int exp_flags();
      int r = 0;
      for (int i = 0; i < 5; i++)
         r = r | (f[i][0] & 3) | ((f[i][1] & 3) << 2) | ((f[i][2] & 3) << 4);
      return r;
   endfunction

   function automatic int jet_sum();
      int s = 0;
      for (int i = 0; i < 5; i++) s += e[i];
      return s;
   endfunction

   function automatic int exp_level(input int s);
      int c = 0;
      for (int k = 0; k < 3; k++) if (s >= thr[k]) c++;
      return c;
   endfunction

   function automatic int exp_energy(input int s);
      return ((s >> 5) > 255) ? 255 : (s >> 5);
   endfunction

   // called at a falling edge; checks the result of the next rising edge
   task automatic apply_check(input string tag);
      int s;
      drive_in();
      s = jet_sum();
      @(posedge clk);
      @(negedge clk);
      chk(int'(out_word[5:0]) == exp_flags(), {"R2 flags ", tag}, int'(out_word[5:0]), exp_flags());
      chk(int'(out_word[15:8]) == exp_energy(s), {"R3 energy ", tag}, int'(out_word[15:8]), exp_energy(s));
      chk(int'(out_word[7:6]) == exp_level(s), {"R4 level ", tag}, int'(out_word[7:6]), exp_level(s));
   endtask

   task automatic write_thr(input int sel, input int val);
      cfg_we = 1'b1;
      cfg_sel = 2'(sel);
      cfg_data = 13'(val);
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel < 3) thr[sel] = val;
   endtask

   task automatic set_sum(input int s);
      for (int i = 0; i < 5; i++) e[i] = s / 5 + ((i < s % 5) ? 1 : 0);
   endtask

   task automatic clear_in();
      for (int i = 0; i < 5; i++) begin
         e[i] = 0;
         for (int k = 0; k < 3; k++) f[i][k] = 0;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
   end

   initial begin : main
      for (int k = 0; k < 3; k++) thr[k] = 8191;
      clear_in();
      for (int i = 0; i < 5; i++) begin e[i] = 1023; f[i][0] = 3; end
      drive_in();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_word == 16'h0, "R1 output zero in reset", int'(out_word), 0);
      rst_n = 1'b1;
      // R1: reset thresholds leave the maximum jet energy at level 0
      apply_check("R1 max energy after reset");
      chk(int'(out_word[7:6]) == 0, "R1 reset thresholds", int'(out_word[7:6]), 0);

      // R2: every single grade bit of every input
      for (int i = 0; i < 5; i++)
         for (int b = 0; b < 6; b++) begin
            clear_in();
            f[i][b/2] = 1 << (b % 2);
            apply_check("single bit");
            chk(int'(out_word[5:0]) == (1 << b), "R2 one-hot position", int'(out_word[5:0]), 1 << b);
         end

      // R3/R4/R2: energy sweep with mixed grades
      write_thr(0, 1000);
      write_thr(1, 2500);
      write_thr(2, 4000);
      for (int s = 0; s <= 5115; s += 11) begin
         clear_in();
         set_sum(s);
         for (int i = 0; i < 5; i++)
            for (int k = 0; k < 3; k++) f[i][k] = (s / 11 + i * 3 + k) % 4 == 0 ? (i % 3) : 0;
         apply_check("sweep");
      end
      clear_in();
      set_sum(5115);
      apply_check("R3 top of range");

      // R4: boundaries on ordered thresholds
      write_thr(0, 100);
      write_thr(1, 200);
      write_thr(2, 300);
      foreach (thr[k]) begin
         for (int d = -1; d <= 1; d++) begin
            clear_in();
            set_sum(thr[k] + d);
            apply_check("R4 boundary");
         end
      end
      // R4: thresholds out of order still count
      write_thr(0, 300);
      write_thr(1, 100);
      clear_in();
      set_sum(150);
      apply_check("R4 unordered");
      chk(int'(out_word[7:6]) == 1, "R4 unordered count", int'(out_word[7:6]), 1);
      write_thr(0, 100);
      write_thr(1, 200);

      // R6: spare select changes nothing
      cfg_we = 1'b1; cfg_sel = 2'd3; cfg_data = 13'd0;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      clear_in();
      set_sum(50);
      apply_check("R6 after spare write");
      chk(int'(out_word[7:6]) == 0, "R6 spare select ignored", int'(out_word[7:6]), 0);

      // R5: write and new data on the same edge
      clear_in();
      set_sum(60);
      drive_in();
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 13'd10;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      chk(int'(out_word[7:6]) == 0, "R5 same-edge uses old threshold", int'(out_word[7:6]), 0);
      thr[0] = 10;
      @(posedge clk);
      @(negedge clk);
      chk(int'(out_word[7:6]) == 1, "R5 next edge uses new threshold", int'(out_word[7:6]), 1);

      // R7: output holds until the next edge
      clear_in();
      set_sum(1000);
      apply_check("R7 first");
      clear_in();
      set_sum(0);
      f[2][1] = 2;
      drive_in();
      #1;
      chk(int'(out_word[15:8]) == (1000 >> 5), "R7 holds before edge", int'(out_word[15:8]), 1000 >> 5);
      apply_check("R7 second");
      chk(int'(out_word[15:8]) == 0, "R7 updates after edge", int'(out_word[15:8]), 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule